// File: doc/BRIEF.md
# Per-Rank Four-Activate Window Limiter

This block tracks, for every rank of a memory channel, how many row activates that rank has received over the last `WINDOW` memory bus cycles. It exposes one permit bit per rank. The command scheduler consults that bit before it opens a row or starts a refresh, and it pulses the strobe whenever it issues either. Refreshes draw the same current as activates, so the scheduler reports them through the same strobe.

Each rank keeps a short history register. An incoming activate enters at the top of that register and walks one position toward bit zero every cycle. A running tally of the set bits is kept next to the register. When the tally reaches four, the rank's permit drops. It returns once the oldest entry falls out of the bottom. Setting `WINDOW` to zero removes the limit, and no history state is built.

Top module: `faw_window_limiter`

## Requirements
- R1: After a synchronous reset every rank's permit bit is high and no history is held.
- R2: A strobe with rank index `act_rank` (a binary rank number) touches only that rank's history. The permits of all other ranks are unchanged by it.
- R3: In any cycle k, the permit of rank r is high exactly when fewer than four strobes to r were sampled at the rising edges that end cycles k-WINDOW through k-1.
- R4: After four strobes to one rank in consecutive cycles c..c+3, its permit is low from cycle c+4 through c+WINDOW and high again in cycle c+WINDOW+1 when no further strobes arrive.
- R5: When a strobe enters and the oldest entry leaves in the same cycle, the tally keeps its value, so the permit keeps its state.
- R6: A strobe sampled while the rank's permit is low is still recorded. It extends the blocked period as a normal entry would.
- R7: The permit bits come from registered state only. A strobe presented in cycle k first affects the permit in cycle k+1.
- R8: With `WINDOW` = 0 every permit bit is constantly high and strobes are ignored. Legal windows range from 0 to 62 cycles.
- R9: Asserting reset in the middle of operation discards all recorded activates. Every permit is high in the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory bus clock |
| rst | input | 1 | Synchronous active-high reset |
| act_valid | input | 1 | Activate or refresh issued this cycle |
| act_rank | input | RANK_W | Binary index of the rank receiving the activate |
| act_allowed | output | NUM_RANKS | Per-rank permit: high when a new activate may be issued |

## Verification
A tally that drifts away from the true number of entries in the history register has two visible effects. It either blocks a rank that has had fewer than four recent activates, or it releases a rank early. In both cases the permit bit shows the error in the first cycle where the bench's count of strobes in the sliding window crosses four. A history bit that is lost, or that lands in the wrong rank, shows up at the latest WINDOW cycles after the strobe, when the permit reopens too soon or too late. For that reason the bench compares every permit bit, on every cycle, against a window count that it keeps itself.

// File: rtl/faw_pkg.sv
package faw_pkg;

    // Most activates allowed inside one window
    localparam int unsigned ACT_LIMIT  = 4;
    // Largest supported window, in bus cycles
    localparam int unsigned WINDOW_MAX = 62;

    // Tally wide enough for a full history register of WINDOW_MAX bits
    typedef logic [5:0] win_count_t;

    // Net effect of one cycle on a rank's tally
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    // One cycle of events seen by a rank's history
    typedef struct packed {
        logic enter;   // new activate injected at the top
        logic leave;   // oldest entry drops out of bit zero
    } win_evt_t;

    function automatic step_e step_kind(win_evt_t evt);
        if (evt.enter && !evt.leave) return STEP_UP;
        if (!evt.enter && evt.leave) return STEP_DOWN;
        return STEP_HOLD;
    endfunction

    function automatic win_count_t apply_step(win_count_t cnt, step_e kind);
        case (kind)
            STEP_UP:   return cnt + win_count_t'(1);
            STEP_DOWN: return cnt - win_count_t'(1);
            default:   return cnt;
        endcase
    endfunction

endpackage

// File: rtl/faw_act_decode.sv
module faw_act_decode #(
    parameter int unsigned NUM_RANKS = 4,
    parameter int unsigned RANK_W    = 2
) (
    input  logic                 act_valid,
    input  logic [RANK_W-1:0]    act_rank,
    output logic [NUM_RANKS-1:0] inject_vec
);

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_dec
        localparam logic [RANK_W-1:0] IDX = RANK_W'(r);
        assign inject_vec[r] = act_valid && (act_rank == IDX);
    end

endmodule

// File: rtl/faw_rank_window.sv
module faw_rank_window
    import faw_pkg::*;
#(
    parameter int unsigned WINDOW = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic inject,
    output logic allowed
);

    localparam int unsigned SR_W = (WINDOW == 0) ? 1 : WINDOW;

    logic [SR_W-1:0] hist_q, hist_d;
    win_count_t      tally_q, tally_d;
    win_evt_t        evt;

    assign evt.enter = inject;
    assign evt.leave = hist_q[0];

    // Age every entry by one position, then inject at the top
    if (SR_W == 1) begin : g_single
        assign hist_d = inject;
    end else begin : g_multi
        assign hist_d = {inject, hist_q[SR_W-1:1]};
    end

    always_comb begin
        tally_d = apply_step(tally_q, step_kind(evt));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q  <= '0;
            tally_q <= '0;
        end else begin
            hist_q  <= hist_d;
            tally_q <= tally_d;
        end
    end

    assign allowed = (tally_q < win_count_t'(ACT_LIMIT));

    // R3: the tally always equals the number of live history entries
    a_r3_tally_tracks_hist: assert property (@(posedge clk) disable iff (rst)
        tally_q == win_count_t'($countones(hist_q)));

    // R1: an activate lands in the top history position
    a_r1_inject_at_top: assert property (@(posedge clk) disable iff (rst)
        inject |=> hist_q[SR_W-1]);

    // R2: without a strobe for this rank nothing enters its history
    a_r2_no_stray_entry: assert property (@(posedge clk) disable iff (rst)
        !inject |=> !hist_q[SR_W-1]);

    // R5: simultaneous entry and exit leave the tally unchanged
    a_r5_net_hold: assert property (@(posedge clk) disable iff (rst)
        (inject && hist_q[0]) |=> (tally_q == $past(tally_q)));

    // R6: a strobe while blocked keeps the rank blocked
    a_r6_blocked_stays: assert property (@(posedge clk) disable iff (rst)
        (!allowed && inject) |=> !allowed);

    if (SR_W > 1) begin : g_age_chk
        // R4: entries age by exactly one position per cycle
        a_r4_age_one_step: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (hist_q[SR_W-2:0] == $past(hist_q[SR_W-1:1])));
    end

endmodule

// File: rtl/faw_window_limiter.sv
module faw_window_limiter
    import faw_pkg::*;
#(
    parameter int unsigned NUM_RANKS = 4,
    parameter int unsigned WINDOW    = 16,
    parameter int unsigned RANK_W    = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 act_valid,
    input  logic [RANK_W-1:0]    act_rank,
    output logic [NUM_RANKS-1:0] act_allowed
);

    logic [NUM_RANKS-1:0] inject_vec;

    faw_act_decode #(
        .NUM_RANKS (NUM_RANKS),
        .RANK_W    (RANK_W)
    ) u_decode (
        .act_valid  (act_valid),
        .act_rank   (act_rank),
        .inject_vec (inject_vec)
    );

    if (WINDOW == 0) begin : g_off
        // Limit disabled: every rank may always activate
        assign act_allowed = '1;
    end else begin : g_on
        for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
            faw_rank_window #(
                .WINDOW (WINDOW)
            ) u_win (
                .clk     (clk),
                .rst     (rst),
                .inject  (inject_vec[r]),
                .allowed (act_allowed[r])
            );
        end
    end

endmodule

// File: tb/test_faw_window_limiter.sv
module test_faw_window_limiter;

    localparam int NR = 4;
    localparam int W  = 16;
    localparam int RW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          act_valid = 1'b0;
    logic [RW-1:0] act_rank = '0;
    logic [NR-1:0] allowed;
    logic [NR-1:0] allowed_off;

    always #5 clk = ~clk;

    faw_window_limiter #(.NUM_RANKS(NR), .WINDOW(W)) i_faw_window_limiter (
        .clk(clk), .rst(rst), .act_valid(act_valid),
        .act_rank(act_rank), .act_allowed(allowed)
    );

    faw_window_limiter #(.NUM_RANKS(NR), .WINDOW(0)) i_faw_window_limiter_off (
        .clk(clk), .rst(rst), .act_valid(act_valid),
        .act_rank(act_rank), .act_allowed(allowed_off)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 0;
    logic hist [NR][1024];

    // Reference record: which rank was strobed in which cycle
    always @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NR; r++)
                for (int i = 0; i < 1024; i++) hist[r][i] = 1'b0;
        end else begin
            for (int r = 0; r < NR; r++)
                hist[r][cyc % 1024] = act_valid && (act_rank == RW'(r));
        end
        cyc = cyc + 1;
    end

    function automatic logic [NR-1:0] expect_vec();
        logic [NR-1:0] e;
        for (int r = 0; r < NR; r++) begin
            int n = 0;
            for (int i = 1; i <= W; i++) begin
                int idx = cyc - i;
                if (idx >= 0 && hist[r][idx % 1024]) n++;
            end
            e[r] = (n < 4);
        end
        return e;
    endfunction

    task automatic expect_eq(string req, logic [NR-1:0] act, logic [NR-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %b expected %b", req, cyc, act, exp);
        end
    endtask

    task automatic check_now(string req);
        expect_eq(req, allowed, expect_vec());
        expect_eq("R8", allowed_off, '1);
    endtask

    task automatic step(bit v, int r, string req);
        @(negedge clk);
        check_now(req);
        act_valid = v;
        act_rank  = RW'(r);
    endtask

    task automatic idle(int n, string req);
        repeat (n) step(1'b0, 0, req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        act_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        expect_eq("R1", allowed, 4'b1111);
        expect_eq("R8", allowed_off, 4'b1111);
    endtask

    task automatic t_burst();
        repeat (4) step(1'b1, 1, "R3");
        #1;
        expect_eq("R7", allowed, 4'b1111);   // 4th strobe not visible yet
        step(1'b0, 0, "R3");
        expect_eq("R2", allowed, 4'b1101);   // only rank 1 blocked
        idle(W + 4, "R4");
    endtask

    task automatic t_net();
        repeat (3) step(1'b1, 2, "R5");
        idle(W - 3, "R5");
        repeat (3) step(1'b1, 2, "R5");      // each enters as one leaves
        step(1'b1, 2, "R5");
        idle(W + 2, "R5");
    endtask

    task automatic t_blocked();
        repeat (4) step(1'b1, 3, "R6");
        repeat (2) step(1'b1, 3, "R6");      // strobes while blocked
        idle(W + 4, "R6");
    endtask

    task automatic t_mixed();
        logic [15:0] lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[3], int'(lfsr[5:4]), "R3");
        end
        idle(W + 2, "R3");
    endtask

    task automatic t_midreset();
        repeat (4) step(1'b1, 0, "R9");
        step(1'b0, 0, "R9");
        expect_eq("R9", allowed, 4'b1110);
        do_reset();
        @(negedge clk);
        expect_eq("R9", allowed, 4'b1111);
        idle(W + 2, "R9");
    endtask

    initial begin
        t_reset();
        t_burst();
        t_net();
        t_blocked();
        t_mixed();
        t_midreset();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule